// File: doc/BRIEF.md
# Overvoltage and Undervoltage Protection Latch

This block sits between the PWM generator and the gate drivers of a multi-channel buck controller. Each channel has a set of digitized comparator flags from its output monitor. The block turns those flags into gate overrides: a power-cycle-only latch for overvoltage, a low-side discharge force with hysteresis release, and an undervoltage low-side blanking that soft-start gates. When no fault is present, the PWM gate requests pass straight through to the gate outputs.

A mode input selects how a fault spreads across channels. In dual mode each channel reacts only to its own monitor. In multiphase mode an overvoltage seen on any channel latches every channel. The latch also pulls each affected channel's enable/fault line low and withdraws the power-good permission. Only the power-cycle reset `por_n` clears the latch.

All flag inputs are sampled on the rising clock edge. The latch, force and undervoltage states are registers, and the gate outputs are combinational from those registers and the PWM requests. A flag therefore affects the gates one clock edge after it is sampled. There is no data stream, so every pin is a plain level.

Top module: `ovuv_guard`

## Requirements
- R1: With `por_n` low, and after it is released with no fault flag set, `hs_gate` equals `pwm_hs`, `ls_gate` equals `pwm_ls`, `en_pull_low` is all zero and `pg_permit` is 1.
- R2: A `mon_ov` bit (output above 120%) sampled high latches its channel. From the next edge, that channel has `hs_gate` 0, `ls_gate` 1 and `en_pull_low` 1.
- R3: Once a channel is latched, its `hs_gate` stays 0 and its `en_pull_low` stays 1 whatever the other inputs do, until `por_n` goes low.
- R4: A forced low side is released on the edge after its `mon_lo` bit (output below 87%) is high and no set condition is present. A latched channel then drives `ls_gate` 0.
- R5: On a latched channel the low-side force sets again on the edge after `mon_hi` (output above 113%) is high.
- R6: With `en_ext_low` high and `mon_hi` high, the low-side force sets on an unlatched channel. It holds until `mon_lo` releases it.
- R7: While a channel's `ss_done` is 0, its undervoltage state stays inactive even with `uv_below` high.
- R8: After soft-start, `uv_below` (below -13%) sets the undervoltage state and `uv_above` (above -9%, with `uv_below` low) clears it. Between the two levels the state holds. While any channel's undervoltage state is active, every unforced `ls_gate` is 0.
- R9: A channel whose enable is pulled low, externally or by its own latch, does not enter the undervoltage state.
- R10: With `multi_mode` 1, a `mon_ov` bit on any channel latches all channels. With `multi_mode` 0, only the flagged channel latches.
- R11: `pg_permit` is 0 whenever any channel is latched.
- R12: An overvoltage flag latches the channel even while its `ss_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Active-low power-cycle reset, asynchronous |
| multi_mode | input | 1 | 1 = multiphase (fault applies to all), 0 = dual (per channel) |
| ss_done | input | NCH | Soft-start complete, per channel |
| en_ext_low | input | NCH | Enable/fault line seen pulled low by another source |
| mon_ov | input | NCH | Output above 120% of target |
| mon_hi | input | NCH | Output above 113% of target |
| mon_lo | input | NCH | Output below 87% of target |
| uv_below | input | NCH | Output below -13% of target |
| uv_above | input | NCH | Output above -9% of target |
| pwm_hs | input | NCH | PWM high-side gate request |
| pwm_ls | input | NCH | PWM low-side gate request |
| hs_gate | output | NCH | High-side gate command |
| ls_gate | output | NCH | Low-side gate command |
| en_pull_low | output | NCH | Pull the enable/fault line low (latched) |
| pg_permit | output | 1 | 0 forces power-good low |

## Verification
A latch bit that is wrongly set or lost shows up at the ports within one edge. The high-side gate stops following PWM, and `en_pull_low` and `pg_permit` flip together. A stuck or missing low-side force appears only while the PWM low-side request differs from the forced value, so the stimulus drives that request opposite to the forced level. An undervoltage state that fails to hold or clear shows as `ls_gate` diverging from `pwm_ls` on the edge after the hysteresis flags change. Routing errors between modes show as the wrong channel's `en_pull_low` on the edge after a single-channel overvoltage flag.

// File: rtl/ovuv_pkg.sv
package ovuv_pkg;
  typedef enum logic {
    SPREAD_OWN = 1'b0,
    SPREAD_ALL = 1'b1
  } spread_e;

  typedef struct packed {
    logic latched;
    logic force_ls;
  } ov_state_t;
endpackage

// File: rtl/ovuv_trip_route.sv
module ovuv_trip_route #(
  parameter int NCH = 2
) (
  input  logic           multi_mode,
  input  logic [NCH-1:0] mon_ov,
  output logic [NCH-1:0] trip
);
  import ovuv_pkg::*;

  spread_e spread;
  logic    any_ov;

  assign spread = spread_e'(multi_mode);
  assign any_ov = |mon_ov;

  for (genvar c = 0; c < NCH; c++) begin : g_route
    always_comb begin
      unique case (spread)
        SPREAD_ALL: trip[c] = any_ov;
        default:    trip[c] = mon_ov[c];
      endcase
    end
  end
endmodule

// File: rtl/ovuv_ov_chan.sv
module ovuv_ov_chan (
  input  logic                clk,
  input  logic                por_n,
  input  logic                trip,
  input  logic                en_ext_low,
  input  logic                mon_hi,
  input  logic                mon_lo,
  output ovuv_pkg::ov_state_t st
);
  import ovuv_pkg::*;

  logic en_pulled;
  logic force_set;
  logic force_clr;

  assign en_pulled = st.latched | en_ext_low;
  assign force_set = trip | (en_pulled & mon_hi);
  assign force_clr = mon_lo & ~force_set;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= '0;
    end else begin
      if (trip) st.latched <= 1'b1;
      if (force_set)      st.force_ls <= 1'b1;
      else if (force_clr) st.force_ls <= 1'b0;
    end
  end

  // R3: the latch never drops without a power cycle
  p_latch_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    st.latched |=> st.latched);

  // R2: a trip sets both the latch and the low-side force
  p_trip_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
    trip |=> (st.latched && st.force_ls));
endmodule

// File: rtl/ovuv_uv_chan.sv
module ovuv_uv_chan (
  input  logic clk,
  input  logic por_n,
  input  logic ss_done,
  input  logic en_pulled,
  input  logic uv_below,
  input  logic uv_above,
  output logic uv_act
);
  logic uv_set;
  logic uv_clr;

  assign uv_set = ss_done & ~en_pulled & uv_below;
  assign uv_clr = ~ss_done | en_pulled | (uv_above & ~uv_below);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      uv_act <= 1'b0;
    else if (uv_clr) uv_act <= 1'b0;
    else if (uv_set) uv_act <= 1'b1;
  end

  // R7: no undervoltage state before soft-start completes
  p_uv_gated_r7: assert property (@(posedge clk) disable iff (!por_n)
    !ss_done |=> !uv_act);

  // R9: a pulled-low enable keeps the undervoltage state off
  p_uv_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
    en_pulled |=> !uv_act);
endmodule

// File: rtl/ovuv_gate_mux.sv
module ovuv_gate_mux #(
  parameter int NCH = 2
) (
  input  ovuv_pkg::ov_state_t [NCH-1:0] st,
  input  logic [NCH-1:0]                uv_act,
  input  logic [NCH-1:0]                pwm_hs,
  input  logic [NCH-1:0]                pwm_ls,
  output logic [NCH-1:0]                hs_gate,
  output logic [NCH-1:0]                ls_gate,
  output logic [NCH-1:0]                en_pull_low
);
  logic uv_any;
  assign uv_any = |uv_act;

  for (genvar c = 0; c < NCH; c++) begin : g_mux
    always_comb begin
      hs_gate[c]     = pwm_hs[c] & ~st[c].latched;
      ls_gate[c]     = st[c].force_ls |
                       (pwm_ls[c] & ~uv_any & ~st[c].latched);
      en_pull_low[c] = st[c].latched;
    end
  end
endmodule

// File: rtl/ovuv_guard.sv
module ovuv_guard #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           multi_mode,
  input  logic [NCH-1:0] ss_done,
  input  logic [NCH-1:0] en_ext_low,
  input  logic [NCH-1:0] mon_ov,
  input  logic [NCH-1:0] mon_hi,
  input  logic [NCH-1:0] mon_lo,
  input  logic [NCH-1:0] uv_below,
  input  logic [NCH-1:0] uv_above,
  input  logic [NCH-1:0] pwm_hs,
  input  logic [NCH-1:0] pwm_ls,
  output logic [NCH-1:0] hs_gate,
  output logic [NCH-1:0] ls_gate,
  output logic [NCH-1:0] en_pull_low,
  output logic           pg_permit
);
  import ovuv_pkg::*;

  logic [NCH-1:0]      trip;
  ov_state_t [NCH-1:0] st;
  logic [NCH-1:0]      uv_act;

  ovuv_trip_route #(.NCH(NCH)) u_route (
    .multi_mode (multi_mode),
    .mon_ov     (mon_ov),
    .trip       (trip)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ovuv_ov_chan u_ov (
      .clk        (clk),
      .por_n      (por_n),
      .trip       (trip[c]),
      .en_ext_low (en_ext_low[c]),
      .mon_hi     (mon_hi[c]),
      .mon_lo     (mon_lo[c]),
      .st         (st[c])
    );

    ovuv_uv_chan u_uv (
      .clk       (clk),
      .por_n     (por_n),
      .ss_done   (ss_done[c]),
      .en_pulled (st[c].latched | en_ext_low[c]),
      .uv_below  (uv_below[c]),
      .uv_above  (uv_above[c]),
      .uv_act    (uv_act[c])
    );

    // R2: a channel pulling its enable low never drives its high side
    p_hs_off_r2: assert property (@(posedge clk) disable iff (!por_n)
      en_pull_low[c] |-> !hs_gate[c]);
  end

  ovuv_gate_mux #(.NCH(NCH)) u_mux (
    .st          (st),
    .uv_act      (uv_act),
    .pwm_hs      (pwm_hs),
    .pwm_ls      (pwm_ls),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .en_pull_low (en_pull_low)
  );

  assign pg_permit = ~|en_pull_low;

  // R10: in multiphase mode any overvoltage flag latches every channel
  p_multi_all_r10: assert property (@(posedge clk) disable iff (!por_n)
    (multi_mode && (|mon_ov)) |=> (&en_pull_low));

  // R11: power-good permission is withdrawn while any channel is latched
  p_pg_drop_r11: assert property (@(posedge clk) disable iff (!por_n)
    (|en_pull_low) |-> !pg_permit);
endmodule

// File: tb/test_ovuv_guard.sv
module test_ovuv_guard;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic por_n, multi_mode;
  logic [NCH-1:0] ss_done, en_ext_low, mon_ov, mon_hi, mon_lo;
  logic [NCH-1:0] uv_below, uv_above, pwm_hs, pwm_ls;
  logic [NCH-1:0] hs_gate, ls_gate, en_pull_low;
  logic pg_permit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ovuv_guard #(.NCH(NCH)) i_ovuv_guard (
    .clk(clk), .por_n(por_n), .multi_mode(multi_mode), .ss_done(ss_done),
    .en_ext_low(en_ext_low), .mon_ov(mon_ov), .mon_hi(mon_hi), .mon_lo(mon_lo),
    .uv_below(uv_below), .uv_above(uv_above), .pwm_hs(pwm_hs), .pwm_ls(pwm_ls),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .en_pull_low(en_pull_low),
    .pg_permit(pg_permit)
  );

  // monitor: compare the result of each edge against the queued expectation
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [6:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hs_gate, ls_gate, en_pull_low, pg_permit};
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got hs=%b ls=%b en=%b pg=%b expected hs=%b ls=%b en=%b pg=%b",
                 t, a[6:5], a[4:3], a[2:1], a[0], e[6:5], e[4:3], e[2:1], e[0]);
      end
    end
  end

  // driver: inputs are already applied at the negedge; queue expectation, run one edge
  task automatic step(input logic [1:0] hs, input logic [1:0] ls,
                      input logic [1:0] en, input logic pg, input string tag);
    exp_q.push_back({hs, ls, en, pg});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; multi_mode = 1'b0; ss_done = 2'b11; en_ext_low = 2'b00;
    mon_ov = 2'b00; mon_hi = 2'b00; mon_lo = 2'b00;
    uv_below = 2'b00; uv_above = 2'b11; pwm_hs = 2'b01; pwm_ls = 2'b10;
    @(negedge clk);
    step(2'b01, 2'b10, 2'b00, 1'b1, "R1 in reset");
    por_n = 1'b1;
    step(2'b01, 2'b10, 2'b00, 1'b1, "R1 idle pass-through");
    pwm_hs = 2'b10; pwm_ls = 2'b01;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R1 pass-through new pattern");

    // undervoltage gated by soft-start
    ss_done = 2'b00; uv_below = 2'b11; uv_above = 2'b00;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R7 uv ignored before soft-start");
    ss_done = 2'b11;
    step(2'b10, 2'b00, 2'b00, 1'b1, "R8 uv trips, low sides off");
    uv_below = 2'b00;
    step(2'b10, 2'b00, 2'b00, 1'b1, "R8 uv holds inside hysteresis");
    uv_above = 2'b11;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R8 uv clears above -9%");

    // enable pulled low suppresses undervoltage
    en_ext_low = 2'b11; uv_below = 2'b11; uv_above = 2'b00;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R9 uv suppressed by low enable");
    en_ext_low = 2'b00; uv_below = 2'b00; uv_above = 2'b11;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R9 restore");

    // external enable low plus above 113% forces the low side
    en_ext_low = 2'b10; mon_hi = 2'b10;
    step(2'b10, 2'b11, 2'b00, 1'b1, "R6 force with external enable low");
    mon_hi = 2'b00;
    step(2'b10, 2'b11, 2'b00, 1'b1, "R6 force holds");
    mon_lo = 2'b10;
    step(2'b10, 2'b01, 2'b00, 1'b1, "R6 force released below 87%");
    en_ext_low = 2'b00; mon_lo = 2'b00;

    // dual-mode overvoltage on channel 0
    mon_ov = 2'b01;
    step(2'b10, 2'b01, 2'b01, 1'b0, "R2 R10 R11 dual-mode latch ch0 only");
    mon_ov = 2'b00; pwm_hs = 2'b11;
    step(2'b10, 2'b01, 2'b01, 1'b0, "R3 latch holds after flag drops");
    mon_lo = 2'b01;
    step(2'b10, 2'b00, 2'b01, 1'b0, "R4 low-side released, high side stays off");
    mon_lo = 2'b00; mon_hi = 2'b01;
    step(2'b10, 2'b01, 2'b01, 1'b0, "R5 force re-arms above 113%");
    mon_hi = 2'b00; mon_lo = 2'b01;
    step(2'b10, 2'b00, 2'b01, 1'b0, "R5 re-armed force released");

    // only a power cycle clears
    por_n = 1'b0; pwm_hs = 2'b01; pwm_ls = 2'b10; mon_lo = 2'b00;
    step(2'b01, 2'b10, 2'b00, 1'b1, "R3 cleared by power cycle");
    por_n = 1'b1;
    step(2'b01, 2'b10, 2'b00, 1'b1, "R1 clean after power cycle");

    // multiphase
    multi_mode = 1'b1; mon_ov = 2'b10;
    step(2'b00, 2'b11, 2'b11, 1'b0, "R10 multiphase latches both channels");
    mon_ov = 2'b00; mon_lo = 2'b11;
    step(2'b00, 2'b00, 2'b11, 1'b0, "R4 both forces released");

    // overvoltage during soft-start
    por_n = 1'b0; mon_lo = 2'b00; multi_mode = 1'b0;
    step(2'b01, 2'b10, 2'b00, 1'b1, "R1 reset before soft-start case");
    por_n = 1'b1; ss_done = 2'b00; mon_ov = 2'b01;
    step(2'b00, 2'b11, 2'b01, 1'b0, "R12 latch during soft-start");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule